// File: doc/BRIEF.md
# Programmable trigger routing matrix

This block carries single-cycle trigger pulses from a set of producer modules to a set of consumer modules. Each consumer owns a select register that holds the ID of the one producer it listens to. When a selected producer pulses, the consumer receives one pulse exactly one clock later. Several consumers may name the same producer, so one producer pulse reaches all of them in the same cycle. A module may act as both consumer and producer. Chains of such modules may route back to their first producer, which gives a trigger sequence that repeats without end.

Software drives the block through a simple synchronous register port. Besides the select registers and a global control register, there is a software-trigger register. One write to it can fire up to four producers at once, which lines up their consumers to the cycle.

Protection against stray writes is two-level. Each select register has a lock bit, and the control register has its own lock bit. A lock bit only takes effect while the external global-lock input is high. A write that is refused is dropped without any trace.

Top module: `trig_route`

## Requirements
- R1: After synchronous reset, all trigger outputs are low, every select register reads 0 with its lock bit clear, and the control register reads 0 (routing disabled, unlocked).
- R2: While routing is enabled, a high level on `trig_in[k]` (producer ID k+1) in one cycle produces a one-cycle high on every consumer output whose select ID equals k+1, in the following cycle. All such consumers pulse in that same cycle.
- R3: A select ID of 0, or an ID greater than NUM_PROD, connects the consumer to nothing, and that output stays low.
- R4: A write to address 1 is a software trigger with four ID fields at bits [7:0], [15:8], [23:16] and [31:24]. Each field holding a valid producer ID acts as one pulse of that producer in the cycle after the write. The routed outputs appear one cycle later still. Fields holding 0 or an out-of-range ID are ignored.
- R5: The software-trigger register clears itself. Each write yields exactly one pulse per named producer, and a read of address 1 returns 0.
- R6: A hardware pulse and a software pulse for the same producer in the same cycle merge into a single one-cycle output pulse.
- R7: While the control enable bit (address 0, bit 0) is clear, all outputs stay low. Select registers remain writable and readable during that time.
- R8: Register map:
  - Address 0 is the control register: bit 0 is enable and bit 1 is lock.
  - Address 2+c is the select register of consumer c: bits [7:0] hold the ID and bit 31 holds its lock.
  - Reads are registered: `rdata` updates on the clock edge that samples `rd_en` and holds its value otherwise.
  - Unused bits and unmapped addresses read 0.
- R9: A write to a select register whose lock bit is set is dropped while `glock_in` is high, and its read-back value stays the same. The same write is accepted while `glock_in` is low.
- R10: A write to the control register while its lock bit is set and `glock_in` is high is dropped, and its read-back value and routing behaviour stay the same.
- R11: With consumer outputs fed back as producer inputs in a ring, a single injected trigger keeps circulating with one hop per cycle, indefinitely, until routing is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glock_in | input | 1 | Global lock; arms the per-register lock bits |
| trig_in | input | NUM_PROD | Producer pulses; bit k is producer ID k+1 |
| trig_out | output | NUM_CONS | Registered consumer pulses |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
The assertions assume three things about the environment:
- Inputs are synchronous to `clk` and settle before each edge.
- `trig_in` may carry any pattern, including a combinational feedback of `trig_out`. That feedback is safe because the output is registered.
- Any number of registers may be written back to back, including during global lock.

The stimulus changes every input only on the falling clock edge. It drives arbitrary hardware patterns, several software-trigger field mixes (including zero and out-of-range IDs), and locked writes with `glock_in` both high and low. It also closes a feedback ring through `trig_out` so that perpetual circulation is exercised. A behavioural model predicts both outputs on every clock.

// File: rtl/trig_route_pkg.sv
package trig_route_pkg;
  localparam int DATA_W        = 32;
  localparam int ID_W          = 8;
  localparam int SW_FIELDS     = DATA_W / ID_W;
  localparam int ADDR_GCTL     = 0;
  localparam int ADDR_SWTRIG   = 1;
  localparam int ADDR_SEL_BASE = 2;
  localparam int GCTL_EN_BIT   = 0;
  localparam int GCTL_LOCK_BIT = 1;
  localparam int SEL_LOCK_BIT  = DATA_W - 1;

  typedef struct packed {
    logic lock;
    logic en;
  } gctl_t;
endpackage

// File: rtl/trig_route_regs.sv
module trig_route_regs
  import trig_route_pkg::*;
#(
  parameter int NUM_CONS = 8,
  parameter int ADDR_W   = 5
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               glock_in,
  input  logic                               wr_en,
  input  logic                               rd_en,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  output logic                               en_o,
  output logic [NUM_CONS-1:0][ID_W-1:0]      sel_id_o,
  output logic                               sw_wr_o
);
  localparam int PAD_W = DATA_W - 1 - ID_W;

  gctl_t                          gctl_q;
  logic [NUM_CONS-1:0][ID_W-1:0]  sel_q;
  logic [NUM_CONS-1:0]            lock_q;
  logic                           wr_gctl;
  logic                           gctl_blocked;
  logic [DATA_W-1:0]              rd_word;
  logic                           unused_wbits;

  assign unused_wbits = ^wdata[SEL_LOCK_BIT-1:ID_W];

  assign wr_gctl      = wr_en && (addr == ADDR_W'(ADDR_GCTL));
  assign gctl_blocked = glock_in && gctl_q.lock;
  assign sw_wr_o      = wr_en && (addr == ADDR_W'(ADDR_SWTRIG));
  assign en_o         = gctl_q.en;
  assign sel_id_o     = sel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gctl_q <= '0;
    end else if (wr_gctl && !gctl_blocked) begin
      gctl_q.lock <= wdata[GCTL_LOCK_BIT];
      gctl_q.en   <= wdata[GCTL_EN_BIT];
    end
  end

  // R10: a locked control register keeps its contents
  a_r10_gctl_lock_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_gctl && glock_in && gctl_q.lock) |=> $stable({gctl_q.lock, gctl_q.en}));

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_sel
    logic hit;
    assign hit = wr_en && (addr == ADDR_W'(ADDR_SEL_BASE + c));

    always_ff @(posedge clk) begin
      if (rst) begin
        sel_q[c]  <= '0;
        lock_q[c] <= 1'b0;
      end else if (hit && !(glock_in && lock_q[c])) begin
        sel_q[c]  <= wdata[ID_W-1:0];
        lock_q[c] <= wdata[SEL_LOCK_BIT];
      end
    end

    // R9: a locked select register keeps its ID and lock bit
    a_r9_sel_lock_hold: assert property (@(posedge clk) disable iff (rst)
      (hit && glock_in && lock_q[c]) |=> ($stable(sel_q[c]) && lock_q[c]));
  end

  always_comb begin
    rd_word = '0;
    if (addr == ADDR_W'(ADDR_GCTL)) begin
      rd_word[GCTL_EN_BIT]   = gctl_q.en;
      rd_word[GCTL_LOCK_BIT] = gctl_q.lock;
    end
    for (int c = 0; c < NUM_CONS; c++) begin
      if (addr == ADDR_W'(ADDR_SEL_BASE + c)) begin
        rd_word = {lock_q[c], {PAD_W{1'b0}}, sel_q[c]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_word;
    end
  end
endmodule

// File: rtl/trig_route_swinj.sv
module trig_route_swinj
  import trig_route_pkg::*;
#(
  parameter int NUM_PROD = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sw_wr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [NUM_PROD-1:0] sw_vec_o
);
  logic [NUM_PROD-1:0] decoded;

  always_comb begin
    decoded = '0;
    for (int f = 0; f < SW_FIELDS; f++) begin
      for (int p = 0; p < NUM_PROD; p++) begin
        if (wdata[f*ID_W +: ID_W] == ID_W'(p + 1)) begin
          decoded[p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sw_vec_o <= '0;
    end else begin
      sw_vec_o <= sw_wr ? decoded : '0;
    end
  end

  // R5: without a fresh write the injected vector is empty next cycle
  a_r5_sw_one_shot: assert property (@(posedge clk) disable iff (rst)
    !sw_wr |=> (sw_vec_o == '0));
endmodule

// File: rtl/trig_route_xbar.sv
module trig_route_xbar
  import trig_route_pkg::*;
#(
  parameter int NUM_PROD = 16,
  parameter int NUM_CONS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           en,
  input  logic [NUM_PROD-1:0]            hw_in,
  input  logic [NUM_PROD-1:0]            sw_in,
  input  logic [NUM_CONS-1:0][ID_W-1:0]  sel_id,
  output logic [NUM_CONS-1:0]            trig_o
);
  logic [NUM_PROD-1:0] src;

  assign src = hw_in | sw_in;

  for (genvar c = 0; c < NUM_CONS; c++) begin : g_cons
    logic hit;

    always_comb begin
      hit = 1'b0;
      for (int p = 0; p < NUM_PROD; p++) begin
        if (sel_id[c] == ID_W'(p + 1)) begin
          hit = src[p];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        trig_o[c] <= 1'b0;
      end else begin
        trig_o[c] <= en && hit;
      end
    end

    // R3: the null ID never delivers a pulse
    a_r3_null_quiet: assert property (@(posedge clk) disable iff (rst)
      (sel_id[c] == '0) |=> !trig_o[c]);

    // R7: routing disabled keeps the output low
    a_r7_disable_quiet: assert property (@(posedge clk) disable iff (rst)
      !en |=> !trig_o[c]);

    for (genvar d = c + 1; d < NUM_CONS; d++) begin : g_pair
      // R2: consumers sharing a producer pulse together
      a_r2_fanout_match: assert property (@(posedge clk) disable iff (rst)
        (sel_id[c] == sel_id[d]) |=> (trig_o[c] == trig_o[d]));
    end
  end
endmodule

// File: rtl/trig_route.sv
module trig_route
  import trig_route_pkg::*;
#(
  parameter int NUM_PROD = 16,
  parameter int NUM_CONS = 8,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                glock_in,
  input  logic [NUM_PROD-1:0] trig_in,
  output logic [NUM_CONS-1:0] trig_out,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata
);
  logic                          en;
  logic                          sw_wr;
  logic [NUM_CONS-1:0][ID_W-1:0] sel_id;
  logic [NUM_PROD-1:0]           sw_vec;

  trig_route_regs #(.NUM_CONS(NUM_CONS), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .glock_in (glock_in),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .en_o     (en),
    .sel_id_o (sel_id),
    .sw_wr_o  (sw_wr)
  );

  trig_route_swinj #(.NUM_PROD(NUM_PROD)) u_swinj (
    .clk      (clk),
    .rst      (rst),
    .sw_wr    (sw_wr),
    .wdata    (wdata),
    .sw_vec_o (sw_vec)
  );

  trig_route_xbar #(.NUM_PROD(NUM_PROD), .NUM_CONS(NUM_CONS)) u_xbar (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .hw_in  (trig_in),
    .sw_in  (sw_vec),
    .sel_id (sel_id),
    .trig_o (trig_out)
  );
endmodule

// File: tb/trig_route_tb.sv
module trig_route_tb;
  localparam int NP = 16;
  localparam int NC = 8;
  localparam int AW = 5;

  logic          clk = 1'b0, rst = 1'b1, glock = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic          loop_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [NP-1:0] hw = '0;
  logic [NP-1:0] trig_in;
  logic [NC-1:0] trig_out;
  logic [31:0]   rdata;

  always #4 clk = ~clk;

  assign trig_in = hw | (loop_en ? NP'(trig_out) : NP'(0));

  trig_route #(.NUM_PROD(NP), .NUM_CONS(NC), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .glock_in(glock), .trig_in(trig_in), .trig_out(trig_out),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  int    checks = 0, errors = 0;
  string tag = "R1";

  // behavioural reference model
  bit          m_en, m_glk;
  int          m_sel[NC];
  bit          m_lk[NC];
  bit [NP-1:0] m_sw;
  bit [NC-1:0] m_out;
  bit [31:0]   m_rd;

  always @(posedge clk) begin : model
    bit [NP-1:0] src;
    bit [NC-1:0] nout;
    bit [NP-1:0] nsw;
    bit [31:0]   nrd;
    int          a;
    if (rst) begin
      m_en = 0; m_glk = 0; m_sw = '0; m_out = '0; m_rd = '0;
      for (int c = 0; c < NC; c++) begin m_sel[c] = 0; m_lk[c] = 0; end
    end else begin
      a = int'(addr);
      src = hw | m_sw;
      if (loop_en) for (int c = 0; c < NC; c++) src[c] = src[c] | m_out[c];
      for (int c = 0; c < NC; c++)
        nout[c] = m_en && m_sel[c] >= 1 && m_sel[c] <= NP && src[m_sel[c]-1];
      nrd = m_rd;
      if (rd_en) begin
        nrd = '0;
        if (a == 0) nrd = {30'b0, m_glk, m_en};
        else if (a >= 2 && a < 2 + NC) nrd = {m_lk[a-2], 23'b0, 8'(m_sel[a-2])};
      end
      nsw = '0;
      if (wr_en) begin
        if (a == 0) begin
          if (!(glock && m_glk)) begin m_en = wdata[0]; m_glk = wdata[1]; end
        end else if (a == 1) begin
          for (int f = 0; f < 4; f++) begin
            int id;
            id = int'(wdata[f*8 +: 8]);
            if (id >= 1 && id <= NP) nsw[id-1] = 1'b1;
          end
        end else if (a >= 2 && a < 2 + NC) begin
          if (!(glock && m_lk[a-2])) begin
            m_sel[a-2] = int'(wdata[7:0]);
            m_lk[a-2]  = wdata[31];
          end
        end
      end
      m_out = nout; m_rd = nrd; m_sw = nsw;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      checks += 2;
      if (trig_out !== m_out) begin
        errors++;
        $display("FAIL %s model trig_out: got %b expected %b", tag, trig_out, m_out);
      end
      if (rdata !== m_rd) begin
        errors++;
        $display("FAIL %s model rdata: got %h expected %h", tag, rdata, m_rd);
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string name, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", name, act, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d);
    addr = AW'(a); wdata = d; wr_en = 1'b1;
    cyc();
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string name);
    addr = AW'(a); rd_en = 1'b1;
    cyc();
    rd_en = 1'b0;
    chk(name, rdata, exp);
  endtask

  initial begin
    logic [15:0] lfsr;
    cyc(3);
    rst = 1'b0;
    cyc();
    tag = "R1";
    chk("R1 outputs after reset", 32'(trig_out), 0);
    rd(0, 0, "R1 control after reset");
    rd(2, 0, "R1 select after reset");

    tag = "R8";
    wr(2, 3); wr(3, 3); wr(4, 5); wr(5, 0); wr(6, 200);
    wr(0, 1);
    rd(0, 1, "R8 control readback");
    rd(2, 3, "R8 select readback");
    rd(6, 32'd200, "R8 large id readback");
    rd(31, 0, "R8 unmapped address");

    tag = "R2";
    hw = 16'h0004;
    cyc();
    chk("R2 fanout of id 3", 32'(trig_out), 32'h03);
    hw = '0;
    cyc();
    chk("R2 pulse ends", 32'(trig_out), 0);

    tag = "R3";
    hw = '1;
    cyc();
    chk("R3 unmapped consumers quiet", 32'(trig_out), 32'h07);
    hw = '0;
    cyc();

    tag = "R4";
    wr(1, 32'h0000_0503);
    chk("R4 no output on injection cycle", 32'(trig_out), 0);
    cyc();
    chk("R4 software pulse routed", 32'(trig_out), 32'h07);
    cyc();
    tag = "R5";
    chk("R5 single pulse", 32'(trig_out), 0);
    rd(1, 0, "R5 trigger register reads zero");
    tag = "R4";
    wr(1, 32'h0500_FF00);
    cyc();
    chk("R4 zero and out-of-range fields ignored", 32'(trig_out), 32'h04);
    cyc();

    tag = "R6";
    wr(1, 32'h0000_0003);
    hw = 16'h0004;
    cyc();
    chk("R6 merged pulse", 32'(trig_out), 32'h03);
    hw = '0;
    cyc();
    chk("R6 merged pulse single", 32'(trig_out), 0);

    tag = "R7";
    wr(0, 0);
    hw = '1;
    cyc();
    chk("R7 disabled outputs low", 32'(trig_out), 0);
    hw = '0;
    wr(7, 3);
    rd(7, 3, "R7 select writable while disabled");

    tag = "R9";
    wr(2, 32'h8000_0003);
    glock = 1'b1;
    wr(2, 32'h0000_0007);
    rd(2, 32'h8000_0003, "R9 locked select unchanged");
    glock = 1'b0;
    wr(2, 32'h0000_0006);
    rd(2, 32'h0000_0006, "R9 write accepted without global lock");

    tag = "R10";
    wr(0, 3);
    glock = 1'b1;
    wr(0, 0);
    rd(0, 3, "R10 locked control unchanged");
    hw = 16'h0004;
    cyc();
    chk("R10 routing still enabled", 32'(trig_out), 32'h22);
    hw = '0;
    glock = 1'b0;
    wr(0, 1);
    rd(0, 1, "R10 control writable without global lock");

    tag = "R2";
    for (int c = 0; c < NC; c++) wr(2 + c, c + 1);
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hw = lfsr;
      cyc();
    end
    hw = '0;
    cyc();

    tag = "R11";
    wr(2, 2); wr(3, 3); wr(4, 1);
    for (int c = 3; c < NC; c++) wr(2 + c, 0);
    loop_en = 1'b1;
    wr(1, 32'h0000_0001);
    cyc();
    for (int i = 0; i < 30; i++) begin
      chk("R11 ring position", 32'(trig_out), 32'h4 >> (i % 3));
      cyc();
    end
    wr(0, 0);
    cyc(2);
    chk("R11 ring stops when disabled", 32'(trig_out), 0);
    loop_en = 1'b0;
    cyc(2);

    summary();
    $finish;
  end
endmodule